// File: doc/BRIEF.md
# Multi-Channel Prescaled Timer Unit

A memory-mapped timer peripheral. One 16-bit prescaler is shared by all channels. It counts down once per clock and produces a one-cycle tick each time it passes zero, so the tick rate is the clock divided by (prescaler reload + 1). Each channel, from one to eight, holds a 32-bit down-counter, a 32-bit reload value and a small control word. An enabled channel steps down on every tick. It expires on the tick that finds it already at zero, so a loaded value N lasts N+1 ticks. On expiry it can raise a sticky pending flag and pulse its own interrupt line, and then it either reloads and keeps running or stops.

Software reaches the unit through a plain strobe port: a write strobe with address and data, and a read strobe whose data appears on the same cycle. The unit registers sit in the first 16-byte block, and channel n occupies block n+1. Inside each block the words at +0x0, +0x4 and +0x8 are the counter, the reload and the control/configuration word.

Top module: `tmr_unit`

## Requirements
- R1: After reset every prescaler, reload, counter and control register reads zero.
- R2: The prescaler value (0x00) and prescaler reload (0x04) keep only write data bits [15:0] and read back zero in bits [31:16].
- R3: A channel decrements exactly once per prescaler tick, and the prescaler ticks every (prescaler reload + 1) clocks, including once per clock for a reload of zero.
- R4: An enabled channel loaded with N expires on the (N+1)-th tick. When restart is clear it then stops: control bit 0 (enable) clears and the counter reads 0xFFFFFFFF.
- R5: When control bit 1 (restart) is set, expiry reloads the counter from the channel reload register and counting continues, so expiries repeat every (reload + 1) ticks.
- R6: On expiry with control bit 3 (interrupt enable) set, control bit 4 (pending) becomes 1 and that channel's irq output is high for exactly one cycle, in the clock cycle after the expiring edge.
- R7: On expiry with interrupt enable clear, pending stays 0 and no irq pulse appears.
- R8: A control write with bit 4 set clears pending. A control write with bit 4 clear leaves pending as it was.
- R9: A control write with bit 2 (load) set copies the reload register into the counter. Bit 2 always reads back as 0.
- R10: A write to a channel's counter (offset +0x0) sets the counter to the written value. If the channel is enabled, counting continues from that value.
- R11: The unit configuration word at 0x08 reads {bit 9 = 1, bit 8 = 1, bits [7:3] = base interrupt number, bits [2:0] = channel count}, and writes to it are ignored.
- R12: Reads of unmapped offsets, including the +0xC word of any block and blocks beyond the configured channel count, return zero, and writes to them change nothing.
- R13: Control bits 5, 6 and 7 up to 31 are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, data captured at the clock edge |
| rd_en | input | 1 | Read strobe, rdata valid in the same cycle |
| addr | input | ADDR_W (8) | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| irq | output | NUM_CH (2) | One interrupt pulse line per channel |

## Verification
The counting path is tried in three shapes. The first is a one-shot expiry with one tick per clock, checked cycle by cycle, which separates expiry at underflow from expiry at zero. The second is a restarting channel with a prescaler reload of zero, and the third is a restarting channel with a prescaler reload of three. The spacing between interrupt pulses in the last two cases separates the prescaler divide from the channel reload. Further patterns cover the pending flag under each value of bit 4, the load bit, direct counter writes while stopped and while running, truncation of the 16-bit registers, and accesses to holes and to absent channels.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the prescaled timer unit.
// Assumes 32-bit word accesses and a 16-byte register block per unit/channel.
package tmr_pkg;
    // Control word bit positions (software visible)
    localparam int CTL_EN  = 0;
    localparam int CTL_RST = 1;
    localparam int CTL_LD  = 2;
    localparam int CTL_IE  = 3;
    localparam int CTL_IP  = 4;
    localparam int CTL_W   = 5;

    // Word selected inside a 16-byte block
    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_RLD  = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_addr_dec.sv
// Address decoder: splits a byte address into a unit-register hit vector,
// a per-channel hit vector and the word selected in the block.
// Assumes block 0 is the unit, block n+1 is channel n; misaligned = unmapped.
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        unit_hit,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_e          field
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;

    // Pick the word in the block; misaligned offsets map to nothing
    always_comb begin
        blk   = addr[ADDR_W-1:4];
        field = (addr[1:0] == 2'b00) ? reg_sel_e'(addr[3:2]) : REG_NONE;
    end

    // Unit block hits: prescaler value, prescaler reload, configuration
    always_comb begin
        unit_hit[0] = (blk == '0) && (field == REG_CNT);
        unit_hit[1] = (blk == '0) && (field == REG_RLD);
        unit_hit[2] = (blk == '0) && (field == REG_CTL);
    end

    // One hit per configured channel; blocks past NUM_CH decode to nothing
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_hit
        assign ch_hit[c] = (blk == BLK_W'(c + 1)) && (field != REG_NONE);
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Shared prescaler: counts down each clock and, when it sits at zero, reloads
// and asserts tick_o for that cycle. Assumes writes are already decoded.
module tmr_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] cnt_o,
    output logic [PRE_W-1:0] rld_o,
    output logic             tick_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] rld_q;

    // Reload register: software write only
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (rld_we) rld_q <= wdata;
    end

    // Prescaler counter: software write wins, else count down or reload
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_we)        cnt_q <= wdata;
        else if (cnt_q == '0)   cnt_q <= rld_q;
        else                    cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;

    // R3
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !cnt_we) |=> (cnt_o == $past(cnt_o) - 1'b1));

    // R3
    pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !cnt_we && !rld_we) |=> (cnt_o == rld_o));
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: 32-bit down-counter, reload register and control word.
// Expires on a tick that finds the counter at zero; may pend an interrupt,
// pulse irq_o for one cycle and reload or stop. Assumes decoded write strobes.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             en_q;
    logic             restart_q;
    logic             ie_q;
    logic             ip_q;
    logic             irq_q;
    logic             expire;
    logic             load_wr;

    assign expire  = tick_i && en_q && (cnt_q == '0);
    assign load_wr = ctl_we && wdata[CTL_LD];

    // Reload register: software write only
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (rld_we) rld_q <= wdata;
    end

    // Counter: direct write, load from reload, or count on tick
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (cnt_we)            cnt_q <= wdata;
        else if (load_wr)           cnt_q <= rld_q;
        else if (expire && restart_q) cnt_q <= rld_q;
        else if (tick_i && en_q)    cnt_q <= cnt_q - 1'b1;
    end

    // Control bits: software write wins, expiry without restart stops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            restart_q <= 1'b0;
            ie_q      <= 1'b0;
        end else if (ctl_we) begin
            en_q      <= wdata[CTL_EN];
            restart_q <= wdata[CTL_RST];
            ie_q      <= wdata[CTL_IE];
        end else if (expire && !restart_q) begin
            en_q      <= 1'b0;
        end
    end

    // Pending flag: set on enabled expiry (wins), cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)                      ip_q <= 1'b0;
        else if (expire && ie_q)         ip_q <= 1'b1;
        else if (ctl_we && wdata[CTL_IP]) ip_q <= 1'b0;
    end

    // Interrupt pulse: one cycle after each enabled expiry
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && ie_q;
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = {ip_q, ie_q, 1'b0, restart_q, en_q};
    assign irq_o = irq_q;

    // R6
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_o[CTL_IP]);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctl_o[CTL_EN] && ctl_o[CTL_IE]));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o[CTL_EN] && !cnt_we && !load_wr) |=> $stable(cnt_o));

    // R9
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[CTL_LD] == 1'b0);
endmodule

// File: rtl/tmr_unit.sv
// Top of the prescaled timer unit: address decode, shared prescaler, an array
// of NUM_CH channels, the read multiplexer and the read-only configuration word.
// Assumes 1 <= NUM_CH <= 8 and full-word strobe accesses.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int BASE_IRQ = 8,
    parameter int ADDR_W   = 8,
    parameter int PRE_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'({1'b1, 1'b1, 5'(BASE_IRQ), 3'(NUM_CH)});

    logic [2:0]        unit_hit;
    logic [NUM_CH-1:0] ch_hit;
    reg_sel_e          field;
    logic [PRE_W-1:0]  pre_cnt;
    logic [PRE_W-1:0]  pre_rld;
    logic              tick;
    logic [DATA_W-1:0] ch_cnt [NUM_CH];
    logic [DATA_W-1:0] ch_rld [NUM_CH];
    logic [CTL_W-1:0]  ch_ctl [NUM_CH];
    logic [DATA_W-1:0] rd_mux;

    tmr_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr     (addr),
        .unit_hit (unit_hit),
        .ch_hit   (ch_hit),
        .field    (field)
    );

    tmr_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_we (wr_en && unit_hit[0]),
        .rld_we (wr_en && unit_hit[1]),
        .wdata  (wdata[PRE_W-1:0]),
        .cnt_o  (pre_cnt),
        .rld_o  (pre_rld),
        .tick_o (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(
            .CNT_W (DATA_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .cnt_we (wr_en && ch_hit[c] && (field == REG_CNT)),
            .rld_we (wr_en && ch_hit[c] && (field == REG_RLD)),
            .ctl_we (wr_en && ch_hit[c] && (field == REG_CTL)),
            .wdata  (wdata),
            .cnt_o  (ch_cnt[c]),
            .rld_o  (ch_rld[c]),
            .ctl_o  (ch_ctl[c]),
            .irq_o  (irq[c])
        );
    end

    // Read multiplexer: unit words first, then the selected channel word
    always_comb begin
        rd_mux = '0;
        if (unit_hit[0]) rd_mux = DATA_W'(pre_cnt);
        if (unit_hit[1]) rd_mux = DATA_W'(pre_rld);
        if (unit_hit[2]) rd_mux = CFG_WORD;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) begin
                case (field)
                    REG_CNT: rd_mux = ch_cnt[c];
                    REG_RLD: rd_mux = ch_rld[c];
                    REG_CTL: rd_mux = DATA_W'(ch_ctl[c]);
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    assign rdata = rd_en ? rd_mux : '0;

    // R12
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unit_hit, ch_hit}));

    // R2
    pre_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (unit_hit[0] || unit_hit[1])) |-> (rdata[31:16] == 16'h0));
endmodule

// File: tb/tmr_unit_tb.sv
// Scoreboard bench: read tasks push expected words into a queue, a negedge
// monitor pops and compares; an irq monitor logs pulse times per channel.
module tmr_unit_tb;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    int unsigned cyc = 0;
    int unsigned t_last [NCH];
    int unsigned t_prev [NCH];
    int unsigned pulses [NCH];
    int unsigned hi_cyc [NCH];
    logic [NCH-1:0] irq_prev = '0;

    tmr_unit #(.NUM_CH(NCH), .BASE_IRQ(8)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Driver tasks: called just after a rising edge, return just after the next
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Read monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underrun", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata === e, t, rdata, e);
            end
        end
    end

    // Irq monitor: cycle stamps, pulse and high-cycle counts per channel
    always @(negedge clk) begin
        cyc++;
        for (int c = 0; c < NCH; c++) begin
            if (irq[c]) hi_cyc[c]++;
            if (irq[c] && !irq_prev[c]) begin
                pulses[c]++;
                t_prev[c] = t_last[c];
                t_last[c] = cyc;
            end
        end
        irq_prev = irq;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            t_last[c] = 0; t_prev[c] = 0; pulses[c] = 0; hi_cyc[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(8'h00, 32'h0, "R1 prescaler value");
        rd(8'h04, 32'h0, "R1 prescaler reload");
        rd(8'h10, 32'h0, "R1 ch0 counter");
        rd(8'h14, 32'h0, "R1 ch0 reload");
        rd(8'h18, 32'h0, "R1 ch0 control");
        rd(8'h28, 32'h0, "R1 ch1 control");
        @(negedge clk);
        chk(irq == '0, "R1 irq idle", 32'(irq), 32'h0);
        @(posedge clk); #1;

        // R11: config word 0x200|0x100|(8<<3)|2, writes ignored
        rd(8'h08, 32'h0000_0342, "R11 config");
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0000_0342, "R11 config after write");

        // R12: holes and absent channels
        wr(8'h14, 32'h0000_0077);
        wr(8'h1C, 32'hDEAD_BEEF);
        wr(8'h30, 32'hDEAD_BEEF);
        wr(8'h34, 32'hDEAD_BEEF);
        rd(8'h0C, 32'h0, "R12 unit hole");
        rd(8'h1C, 32'h0, "R12 ch0 hole");
        rd(8'h30, 32'h0, "R12 absent channel counter");
        rd(8'h34, 32'h0, "R12 absent channel reload");
        rd(8'h14, 32'h0000_0077, "R12 ch0 reload untouched");
        rd(8'h11, 32'h0, "R12 misaligned");

        // R2: 16-bit truncation
        wr(8'h04, 32'h1234_0003);
        rd(8'h04, 32'h0000_0003, "R2 prescaler reload");
        wr(8'h00, 32'hABCD_0007);
        rd(8'h00, 32'h0000_0007, "R2 prescaler value");
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);

        // R4/R6: one-shot, one tick per clock, N=3 expires on 4th tick
        wr(8'h10, 32'd3);
        wr(8'h18, 32'h0000_0009);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(irq[0] == 1'b0, "R4 no expiry before N+1 ticks", 32'(irq[0]), 32'h0);
        @(negedge clk);
        chk(irq[0] == 1'b1, "R6 irq after N+1 ticks", 32'(irq[0]), 32'h1);
        @(negedge clk);
        chk(irq[0] == 1'b0, "R6 irq one cycle", 32'(irq[0]), 32'h0);
        @(posedge clk); #1;
        idle(4);
        rd(8'h10, 32'hFFFF_FFFF, "R4 counter after underflow");
        rd(8'h18, 32'h0000_0018, "R4 stopped, R6 pending set");
        chk(pulses[0] == 1, "R6 pulse count", pulses[0], 32'd1);
        chk(hi_cyc[0] == 1, "R6 pulse width", hi_cyc[0], 32'd1);

        // R8: pending write semantics
        wr(8'h18, 32'h0000_0008);
        rd(8'h18, 32'h0000_0018, "R8 bit4 clear keeps pending");
        wr(8'h18, 32'h0000_0018);
        rd(8'h18, 32'h0000_0008, "R8 bit4 set clears pending");

        // R7: expiry without interrupt enable
        wr(8'h20, 32'd1);
        wr(8'h28, 32'h0000_0001);
        idle(10);
        rd(8'h28, 32'h0, "R7 no pending, stopped");
        rd(8'h20, 32'hFFFF_FFFF, "R7 counter underflowed");
        chk(pulses[1] == 0, "R7 no irq pulse", pulses[1], 32'd0);

        // R9: load bit copies reload, reads zero
        wr(8'h24, 32'h0000_0100);
        wr(8'h28, 32'h0000_0004);
        rd(8'h20, 32'h0000_0100, "R9 counter loaded");
        rd(8'h28, 32'h0, "R9 load bit reads zero");

        // R10: direct counter write, stopped then running
        wr(8'h20, 32'h0000_0055);
        idle(5);
        rd(8'h20, 32'h0000_0055, "R10 counter write while stopped");
        wr(8'h28, 32'h0000_0001);
        wr(8'h28, 32'h0000_0000);
        rd(8'h20, 32'h0000_0054, "R10 one decrement while enabled");
        wr(8'h20, 32'h0000_0010);
        wr(8'h28, 32'h0000_0001);
        idle(4);
        wr(8'h28, 32'h0000_0000);
        rd(8'h20, 32'h0000_000B, "R10 counting resumes from written value");

        // R13: unsupported control bits dropped
        wr(8'h28, 32'hFFFF_FF6A);
        rd(8'h28, 32'h0000_000A, "R13 reserved bits read zero");
        wr(8'h28, 32'h0);

        // R5/R3: restart, one tick per clock, reload 2 -> every 3 clocks
        wr(8'h14, 32'd2);
        wr(8'h18, 32'h0000_000F);
        idle(30);
        wr(8'h18, 32'h0000_0010);
        chk(t_last[0] - t_prev[0] == 3, "R5 restart period (prescale 1)",
            t_last[0] - t_prev[0], 32'd3);
        chk(hi_cyc[0] == pulses[0], "R6 each pulse one cycle",
            hi_cyc[0], pulses[0]);

        // R3: prescaler reload 3, channel reload 5 -> every 24 clocks
        wr(8'h04, 32'd3);
        wr(8'h24, 32'd5);
        wr(8'h28, 32'h0000_000F);
        idle(120);
        wr(8'h28, 32'h0000_0010);
        chk(t_last[1] - t_prev[1] == 24, "R3 tick divide (prescale 4)",
            t_last[1] - t_prev[1], 32'd24);
        chk(pulses[1] >= 4, "R5 repeated expiries", pulses[1], 32'd4);

        idle(2);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule